// File: doc/BRIEF.md
# USB Host Frame Transaction Scheduler

This block decides, inside each USB frame, which pipe of a host controller may start the next bus transaction. There are eight pipes. Pipe 0 is the default control pipe and pipes 1 to 7 are general pipes. While the run input is high, the block emits a start-of-frame strobe once per frame period. After each strobe it runs three phases in a fixed order, and each phase has its own fixed pipe order. The first phase serves periodic (isochronous or interrupt) pipes. The second checks for a pending control setup on pipe 0. The third serves bulk and control data or status stages, and repeats for as long as frame time allows.

Only one transaction is outstanding at a time. The block raises a grant with a pipe index and a transaction kind, and holds it until the protocol engine returns a completion pulse. A completion may follow an ACK or a NAK; in both cases the scan moves on to the next pipe. The engine also supplies a remaining-frame-time value. No grant is issued unless that value covers a worst-case transaction length. When the run input is cleared, one last start-of-frame goes out and the block then goes quiet.

Top module: `usb_frame_sched`

## Requirements
- R1: After synchronous reset, and for as long as `run_en` stays low, the block emits no start-of-frame and no grant, and `grant_kind` reads 00.
- R2: From the idle state with `run_en` high, `sof_stb` pulses for one cycle on the next clock edge. While running, later pulses follow every `FRAME_CYC` cycles, and two pulses are never closer than `FRAME_CYC` cycles.
- R3: Within a frame, all periodic grants come before any setup grant, and all setup grants come before any data/status grant.
- R4: Periodic grants use `grant_kind` 01. They are taken from `per_rdy` in pipe order 1, 2, 6, 7. The `per_rdy` bits of pipes 0, 3, 4 and 5 are ignored.
- R5: A setup grant uses `grant_kind` 10, is requested by `setup_rdy`, and always names pipe 0.
- R6: Data/status grants use `grant_kind` 11. They are taken from `data_rdy` in pipe order 0, 1, 2, 3, 4, 5. The `data_rdy` bits of pipes 6 and 7 are ignored.
- R7: At most one grant is outstanding. `grant_vld`, `grant_pipe` and `grant_kind` hold until `xfer_done`. The scan then moves to the next pipe in order, even if the served pipe is still ready, so a periodic pipe is granted at most once per frame.
- R8: A data/status pass that issued at least one grant restarts at pipe 0. A pass with no grant ends all scheduling until the next start-of-frame.
- R9: A grant is issued only when `time_left` >= `MIN_SLOT`. If a ready pipe meets a smaller value, no further grant is issued in that frame.
- R10: If a transaction is still outstanding when the frame period expires, `sof_stb` is held back and pulses on the edge after the one that samples `xfer_done`.
- R11: After `run_en` falls, no new grant is issued and exactly one more start-of-frame is sent at the frame boundary, after which the block stays idle. Raising `run_en` again long afterwards gives a start-of-frame on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Enables frame generation and scheduling |
| per_rdy | input | NPIPE | Per-pipe periodic transfer ready |
| setup_rdy | input | 1 | Setup stage pending on pipe 0 |
| data_rdy | input | NPIPE | Per-pipe data or status stage ready |
| time_left | input | TIME_W | Remaining frame time from the protocol engine |
| xfer_done | input | 1 | One-cycle completion of the granted transaction |
| sof_stb | output | 1 | One-cycle start-of-frame request |
| grant_vld | output | 1 | A transaction is granted and outstanding |
| grant_pipe | output | $clog2(NPIPE) | Granted pipe index |
| grant_kind | output | 2 | 00 none, 01 periodic, 10 setup, 11 data/status |

## Verification
The scoreboard is fed several readiness patterns:
- Every flag set, including those that must be ignored. This shows the phase order and the per-phase pipe orders as a whole.
- A sparse out-of-order set. This separates a true fixed order from one that happens to follow the flag positions.
- A periodic pipe that stays ready after completion, as after a NAK. This tells "once per frame" apart from "while ready".
- A completion that re-arms a lower data pipe. This shows the data/status pass wrapping back to pipe 0 rather than ending.

Further patterns cover the rest:
- A frame with a short time budget, which must produce no grant.
- A transfer that runs past the frame boundary, which must delay the strobe by an exact number of cycles.
- Dropping `run_en` at a strobe, which must leave exactly one strobe and no grant.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT, ST_HOLD} fs_state_t;
  typedef enum logic [1:0] {PH_PER, PH_SETUP, PH_DATA} fs_phase_t;
  typedef enum logic [1:0] {
    GK_NONE  = 2'd0,
    GK_PER   = 2'd1,
    GK_SETUP = 2'd2,
    GK_DATA  = 2'd3
  } fs_kind_t;

  // slots per scan phase
  localparam int PER_SLOTS  = 4;
  localparam int DATA_SLOTS = 6;
endpackage

// File: rtl/fs_frame_timer.sv
module fs_frame_timer #(
  parameter int FRAME_CYC = 200,
  localparam int CW = $clog2(FRAME_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic reload,
  output logic due
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (reload)
      cnt_q <= CW'(FRAME_CYC - 1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // frame period has elapsed since the last strobe
  assign due = (cnt_q == '0);
endmodule

// File: rtl/fs_scan_order.sv
module fs_scan_order
  import fs_pkg::*;
#(
  parameter int PIPE_W = 3
) (
  input  fs_phase_t         phase,
  input  logic [2:0]        pos,
  output logic [PIPE_W-1:0] pipe,
  output logic              last,
  output fs_kind_t          kind
);
  always_comb begin
    unique case (phase)
      PH_PER: begin
        unique case (pos)
          3'd0:    pipe = PIPE_W'(1);
          3'd1:    pipe = PIPE_W'(2);
          3'd2:    pipe = PIPE_W'(6);
          default: pipe = PIPE_W'(7);
        endcase
        last = (pos == 3'(PER_SLOTS - 1));
        kind = GK_PER;
      end
      PH_SETUP: begin
        pipe = '0;
        last = 1'b1;
        kind = GK_SETUP;
      end
      default: begin
        pipe = PIPE_W'(pos);
        last = (pos == 3'(DATA_SLOTS - 1));
        kind = GK_DATA;
      end
    endcase
  end
endmodule

// File: rtl/fs_grant_reg.sv
module fs_grant_reg #(
  parameter int PIPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_set,
  input  logic              load,
  input  logic              clr,
  input  logic [PIPE_W-1:0] pipe_in,
  input  logic [1:0]        kind_in,
  output logic              sof_stb,
  output logic              grant_vld,
  output logic [PIPE_W-1:0] grant_pipe,
  output logic [1:0]        grant_kind
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sof_stb    <= 1'b0;
      grant_vld  <= 1'b0;
      grant_pipe <= '0;
      grant_kind <= 2'd0;
    end else begin
      sof_stb <= sof_set;
      if (load) begin
        grant_vld  <= 1'b1;
        grant_pipe <= pipe_in;
        grant_kind <= kind_in;
      end else if (clr) begin
        grant_vld  <= 1'b0;
        grant_pipe <= '0;
        grant_kind <= 2'd0;
      end
    end
  end
endmodule

// File: rtl/usb_frame_sched.sv
module usb_frame_sched
  import fs_pkg::*;
#(
  parameter int NPIPE     = 8,
  parameter int FRAME_CYC = 200,
  parameter int TIME_W    = 16,
  parameter int MIN_SLOT  = 20,
  localparam int PIPE_W   = $clog2(NPIPE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [NPIPE-1:0]  per_rdy,
  input  logic              setup_rdy,
  input  logic [NPIPE-1:0]  data_rdy,
  input  logic [TIME_W-1:0] time_left,
  input  logic              xfer_done,
  output logic              sof_stb,
  output logic              grant_vld,
  output logic [PIPE_W-1:0] grant_pipe,
  output logic [1:0]        grant_kind
);
  fs_state_t st_q, st_d, adv_st;
  fs_phase_t ph_q, ph_d, adv_ph;
  logic [2:0] pos_q, pos_d, adv_pos;
  logic hit_q, hit_d, adv_hit;
  logic sof_set, g_load, g_clr;
  logic frame_due, cur_rdy, time_ok, slot_last;
  logic [PIPE_W-1:0] slot_pipe;
  fs_kind_t slot_kind;

  fs_frame_timer #(.FRAME_CYC(FRAME_CYC)) timer_i (
    .clk(clk), .rst(rst), .reload(sof_set), .due(frame_due)
  );

  fs_scan_order #(.PIPE_W(PIPE_W)) order_i (
    .phase(ph_q), .pos(pos_q), .pipe(slot_pipe), .last(slot_last), .kind(slot_kind)
  );

  fs_grant_reg #(.PIPE_W(PIPE_W)) out_i (
    .clk(clk), .rst(rst), .sof_set(sof_set), .load(g_load), .clr(g_clr),
    .pipe_in(slot_pipe), .kind_in(slot_kind),
    .sof_stb(sof_stb), .grant_vld(grant_vld),
    .grant_pipe(grant_pipe), .grant_kind(grant_kind)
  );

  always_comb begin
    unique case (ph_q)
      PH_PER:   cur_rdy = per_rdy[slot_pipe];
      PH_SETUP: cur_rdy = setup_rdy;
      default:  cur_rdy = data_rdy[slot_pipe];
    endcase
  end

  assign time_ok = (time_left >= TIME_W'(MIN_SLOT));

  // position that follows the current slot
  always_comb begin
    adv_st  = ST_SCAN;
    adv_ph  = ph_q;
    adv_pos = pos_q + 3'd1;
    adv_hit = hit_q;
    unique case (ph_q)
      PH_PER: begin
        if (slot_last) begin
          adv_ph  = PH_SETUP;
          adv_pos = 3'd0;
        end
      end
      PH_SETUP: begin
        adv_ph  = PH_DATA;
        adv_pos = 3'd0;
        adv_hit = 1'b0;
      end
      default: begin
        if (slot_last) begin
          adv_pos = 3'd0;
          adv_hit = 1'b0;
          if (!hit_q) adv_st = ST_HOLD;
        end
      end
    endcase
  end

  always_comb begin
    st_d    = st_q;
    ph_d    = ph_q;
    pos_d   = pos_q;
    hit_d   = hit_q;
    sof_set = 1'b0;
    g_load  = 1'b0;
    g_clr   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (run_en && frame_due) begin
          sof_set = 1'b1;
          st_d    = ST_SCAN;
          ph_d    = PH_PER;
          pos_d   = 3'd0;
          hit_d   = 1'b0;
        end
      end
      ST_WAIT: begin
        if (xfer_done) begin
          g_clr = 1'b1;
          st_d  = adv_st;
          ph_d  = adv_ph;
          pos_d = adv_pos;
          hit_d = adv_hit;
        end
      end
      default: begin
        if (frame_due) begin
          sof_set = 1'b1;
          st_d    = run_en ? ST_SCAN : ST_IDLE;
          ph_d    = PH_PER;
          pos_d   = 3'd0;
          hit_d   = 1'b0;
        end else if (st_q == ST_SCAN) begin
          if (!run_en) begin
            st_d = ST_HOLD;
          end else if (cur_rdy) begin
            if (time_ok) begin
              g_load = 1'b1;
              st_d   = ST_WAIT;
              if (ph_q == PH_DATA) hit_d = 1'b1;
            end else begin
              st_d = ST_HOLD;
            end
          end else begin
            st_d  = adv_st;
            ph_d  = adv_ph;
            pos_d = adv_pos;
            hit_d = adv_hit;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      ph_q  <= PH_PER;
      pos_q <= 3'd0;
      hit_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ph_q  <= ph_d;
      pos_q <= pos_d;
      hit_q <= hit_d;
    end
  end
endmodule

// File: rtl/fs_sched_checker.sv
module fs_sched_checker #(
  parameter int NPIPE     = 8,
  parameter int FRAME_CYC = 200,
  parameter int TIME_W    = 16,
  parameter int MIN_SLOT  = 20,
  localparam int PIPE_W   = $clog2(NPIPE)
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic [TIME_W-1:0] time_left,
  input logic              xfer_done,
  input logic              sof_stb,
  input logic              grant_vld,
  input logic [PIPE_W-1:0] grant_pipe,
  input logic [1:0]        grant_kind
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= 32'd0;
      seen_q <= 1'b0;
    end else if (sof_stb) begin
      gap_q  <= 32'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 32'hFFFF_FFFF) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  p_sof_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (sof_stb && seen_q) |-> (gap_q >= 32'(FRAME_CYC)));

  p_sof_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    sof_stb |=> !sof_stb);

  p_per_pipe_r4: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && grant_kind == 2'd1) |->
      (grant_pipe == PIPE_W'(1) || grant_pipe == PIPE_W'(2) ||
       grant_pipe == PIPE_W'(6) || grant_pipe == PIPE_W'(7)));

  p_setup_pipe_r5: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && grant_kind == 2'd2) |-> (grant_pipe == '0));

  p_data_pipe_r6: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && grant_kind == 2'd3) |-> (grant_pipe <= PIPE_W'(5)));

  p_hold_grant_r7: assert property (@(posedge clk) disable iff (rst)
    (grant_vld && !xfer_done) |=>
      (grant_vld && $stable(grant_pipe) && $stable(grant_kind)));

  p_budget_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> ($past(time_left) >= TIME_W'(MIN_SLOT)));

  p_no_sof_in_xfer_r10: assert property (@(posedge clk) disable iff (rst)
    sof_stb |-> !grant_vld);

  p_run_gate_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_vld) |-> $past(run_en));
endmodule

bind usb_frame_sched fs_sched_checker #(
  .NPIPE(NPIPE), .FRAME_CYC(FRAME_CYC), .TIME_W(TIME_W), .MIN_SLOT(MIN_SLOT)
) chk_i (
  .clk(clk), .rst(rst), .run_en(run_en), .time_left(time_left),
  .xfer_done(xfer_done), .sof_stb(sof_stb), .grant_vld(grant_vld),
  .grant_pipe(grant_pipe), .grant_kind(grant_kind)
);

// File: tb/usb_frame_sched_tb_top.sv
module usb_frame_sched_tb_top;
  localparam int NPIPE = 8;
  localparam int FRAME = 200;
  localparam int TW    = 16;
  localparam int MINS  = 20;

  typedef struct packed {
    logic [2:0] pipe;
    logic [1:0] kind;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run_en = 1'b0;
  logic [NPIPE-1:0] per_rdy = '0;
  logic setup_rdy = 1'b0;
  logic [NPIPE-1:0] data_rdy = '0;
  logic [TW-1:0] time_left = 16'd1000;
  logic xfer_done = 1'b0;
  logic sof_stb, grant_vld;
  logic [2:0] grant_pipe;
  logic [1:0] grant_kind;

  item_t exp_q[$];
  int n_chk = 0, n_err = 0;
  int cyc = 0, sof_cnt = 0, last_sof = 0, last_gap = 0, grant_cnt = 0;
  int lat = 2, rcnt = 0;
  bit busy = 0, clr_per = 1, rearm_en = 0;
  int rearm_from = 0, rearm_to = 0;

  always #2.5 clk = ~clk;

  usb_frame_sched #(.NPIPE(NPIPE), .FRAME_CYC(FRAME), .TIME_W(TW), .MIN_SLOT(MINS)) dut_i (
    .clk(clk), .rst(rst), .run_en(run_en), .per_rdy(per_rdy), .setup_rdy(setup_rdy),
    .data_rdy(data_rdy), .time_left(time_left), .xfer_done(xfer_done),
    .sof_stb(sof_stb), .grant_vld(grant_vld), .grant_pipe(grant_pipe), .grant_kind(grant_kind)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic push(input int p, input int k);
    item_t it;
    it.pipe = 3'(p);
    it.kind = 2'(k);
    exp_q.push_back(it);
  endtask

  task automatic wait_sof();
    @(negedge clk);
    while (!sof_stb) @(negedge clk);
    #1;
  endtask

  // monitor and protocol-engine responder
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "WDOG", "watchdog expired", cyc, 150000);
        finish_run();
      end
      if (sof_stb) begin
        sof_cnt++;
        last_gap = cyc - last_sof;
        last_sof = cyc;
        chk(!busy, "R10", "strobe while transfer open", 1, 0);
      end
      if (xfer_done) begin
        xfer_done = 1'b0;
        busy = 0;
      end else if (busy) begin
        if (!grant_vld) chk(0, "R7", "grant dropped before done", 0, 1);
        if (rcnt > 1) rcnt--;
        else begin
          xfer_done = 1'b1;
          if (grant_kind == 2'd1 && clr_per) per_rdy[grant_pipe] = 1'b0;
          if (grant_kind == 2'd2) setup_rdy = 1'b0;
          if (grant_kind == 2'd3) begin
            data_rdy[grant_pipe] = 1'b0;
            if (rearm_en && int'(grant_pipe) == rearm_from) begin
              data_rdy[rearm_to] = 1'b1;
              rearm_en = 0;
            end
          end
        end
      end
      if (!busy && !xfer_done && grant_vld) begin
        grant_cnt++;
        busy = 1;
        rcnt = lat;
        if (exp_q.size() == 0) begin
          chk(0, "R3", "unexpected grant pipe", int'(grant_pipe), -1);
        end else begin
          item_t e;
          e = exp_q.pop_front();
          chk(grant_pipe == e.pipe && grant_kind == e.kind, "R3",
              "grant pipe*4+kind", int'(grant_pipe) * 4 + int'(grant_kind),
              int'(e.pipe) * 4 + int'(e.kind));
        end
      end
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    // R1: idle after reset with run_en low
    chk(sof_cnt == 0, "R1", "strobes while stopped", sof_cnt, 0);
    chk(!grant_vld && grant_kind == 2'd0, "R1", "grant after reset", int'(grant_vld), 0);

    // R3 R4 R5 R6: full pattern, ignored bits set too
    per_rdy   = 8'b1100_1111;
    setup_rdy = 1'b1;
    data_rdy  = 8'b1110_0011;
    push(1, 1); push(2, 1); push(6, 1); push(7, 1);
    push(0, 2);
    push(0, 3); push(1, 3); push(5, 3);
    run_en = 1'b1;
    @(negedge clk);
    chk(sof_stb == 1'b1, "R2", "strobe on first edge", int'(sof_stb), 1);
    wait_sof();
    chk(last_gap == FRAME, "R2", "frame period", last_gap, FRAME);
    chk(exp_q.size() == 0, "R4", "pending after full pattern", exp_q.size(), 0);
    per_rdy = '0; data_rdy = '0;

    // R4 R6: sparse pattern
    wait_sof();
    lat = 3;
    per_rdy = 8'b1000_0100; data_rdy = 8'b0001_1000;
    push(2, 1); push(7, 1); push(3, 3); push(4, 3);
    wait_sof();
    chk(exp_q.size() == 0, "R6", "pending after sparse", exp_q.size(), 0);
    chk(last_gap == FRAME, "R2", "frame period sparse", last_gap, FRAME);

    // R7: periodic pipe stays ready (NAK), once per frame
    clr_per = 0; lat = 2;
    per_rdy = 8'b0000_0010;
    push(1, 1); push(1, 1);
    wait_sof();
    chk(exp_q.size() == 1, "R7", "grants in first NAK frame", 2 - exp_q.size(), 1);
    wait_sof();
    per_rdy = '0; clr_per = 1;
    chk(exp_q.size() == 0, "R7", "pending after NAK frames", exp_q.size(), 0);

    // R8: pass restarts at pipe 0 after a hit
    data_rdy = 8'b0001_0100;
    rearm_en = 1; rearm_from = 2; rearm_to = 1;
    push(2, 3); push(4, 3); push(1, 3);
    wait_sof();
    chk(exp_q.size() == 0, "R8", "pending after repeat pass", exp_q.size(), 0);

    // R9: budget too small
    time_left = 16'd10;
    data_rdy = 8'b0000_1000;
    base = grant_cnt;
    wait_sof();
    chk(grant_cnt == base, "R9", "grants with low budget", grant_cnt - base, 0);
    time_left = 16'd1000;
    push(3, 3);
    wait_sof();
    chk(exp_q.size() == 0, "R9", "pending after budget restored", exp_q.size(), 0);

    // R10: transfer crosses the frame boundary
    lat = 250;
    per_rdy = 8'b0000_0010;
    push(1, 1);
    wait_sof();
    chk(last_gap == 253, "R10", "delayed frame gap", last_gap, 253);
    chk(exp_q.size() == 0, "R10", "pending after overrun", exp_q.size(), 0);
    lat = 2;
    wait_sof();
    chk(last_gap == FRAME, "R2", "period after overrun", last_gap, FRAME);

    // R11: stop at a strobe with work pending
    wait_sof();
    data_rdy = 8'b0010_0000;
    run_en = 1'b0;
    base = sof_cnt;
    begin
      int g0;
      g0 = grant_cnt;
      repeat (3 * FRAME + 50) @(negedge clk);
      #1;
      chk(sof_cnt == base + 1, "R11", "strobes after stop", sof_cnt - base, 1);
      chk(grant_cnt == g0, "R11", "grants after stop", grant_cnt - g0, 0);
    end
    data_rdy = '0;
    @(negedge clk);
    run_en = 1'b1;
    @(negedge clk);
    chk(sof_stb == 1'b1, "R11", "strobe on restart", int'(sof_stb), 1);
    run_en = 1'b0;
    repeat (2 * FRAME) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "queue empty at end", exp_q.size(), 0);
    finish_run();
  end
endmodule